// File: doc/BRIEF.md
# Fixed-Priority Nested Interrupt Controller

This block collects up to eight interrupt sources and presents one interrupt line to a processor. Source 0 has the highest priority and source 7 the lowest. A rising edge on a source input latches a pending request. The block raises its interrupt output whenever a pending request may be serviced under the nesting rules.

When the processor strobes acknowledge, the block picks the winning pending request and marks it as in service. In the same clock edge it registers an 8-bit vector. The vector joins a programmable 5-bit base with the 3-bit number of the winning source. While a source is in service, sources of the same or lower priority cannot interrupt, but more urgent sources still can, so handlers nest.

Software finishes a handler through the write port with an end-of-interrupt command. The command either clears the most urgent in-service source or clears a named source. The vector base is written through the same port.

Top module: `nic_top`

## Requirements
- R1: After synchronous reset, `irq_o` is 0, `vec_o` is 0x00, the base is 0, and no request is pending or in service.
- R2: A request is latched on a rising edge of its `req_i` bit. A level held high does not latch again after the request has been granted. A latched request clears when it is granted.
- R3: With nothing in service, `irq_o` is high in the cycle after a request is latched.
- R4: The acknowledge grants the pending request with the lowest source number.
- R5: On the clock edge that samples `ack_i` high, `vec_o` is loaded with the base in bits 7:3 and the source number in bits 2:0. It holds that value until the next acknowledge.
- R6: A granted acknowledge sets the in-service bit of the granted source and clears its pending request.
- R7: While a source is in service, pending requests of equal or lower priority keep `irq_o` low.
- R8: A pending request of strictly higher priority than every in-service source drives `irq_o` high, so handlers nest.
- R9: An acknowledge while `irq_o` is low returns source number 3'b111 with the current base, and sets no in-service bit.
- R10: A write with `wr_sel_i`=0 loads `wr_data_i[7:3]` as the base at any time. The new base is used from the next acknowledge on.
- R11: A write with `wr_sel_i`=1 and `wr_data_i[3]`=0 clears the highest-priority in-service bit.
- R12: A write with `wr_sel_i`=1 and `wr_data_i[3]`=1 clears only the in-service bit numbered `wr_data_i[2:0]`.
- R13: An in-service bit stays set until an end-of-interrupt command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Interrupt source inputs, bit 0 most urgent |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| wr_en_i | input | 1 | Write strobe for the command port |
| wr_sel_i | input | 1 | 0 selects a base write, 1 selects an end-of-interrupt command |
| wr_data_i | input | 8 | Write data: base in bits 7:3; or specific flag in bit 3 and source number in bits 2:0 |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Registered vector byte |

## Verification
The bench raises two sources together and expects the lower-numbered one to win. A reversed encoder would return the other source.

Several tests nest a more urgent source over an in-service one. A lower-priority request raised during that time must stay masked; a design that compares with the wrong bound would let it interrupt, or would block the nesting source. With two sources in service, the bench checks which one each end-of-interrupt form removes. It watches whether a request parked between the two sources is released, so a design that clears the wrong in-service bit releases the interrupt at the wrong moment.

An empty acknowledge must give source 7 without taking source 7 into service. A request held high must not come back after its handler ends. A base written while a handler runs must show up on the next vector.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int NSRC   = 8;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - IDX_W;

    typedef logic [NSRC-1:0]   src_mask_t;
    typedef logic [IDX_W-1:0]  src_idx_t;
    typedef logic [BASE_W-1:0] vec_base_t;

    typedef enum logic {
        WR_BASE = 1'b0,
        WR_EOI  = 1'b1
    } wr_target_e;

    typedef struct packed {
        logic     valid;
        logic     specific;
        src_idx_t idx;
    } eoi_cmd_t;

    typedef struct packed {
        logic     found;
        src_idx_t idx;
    } prio_t;

    function automatic src_mask_t idx_to_mask(src_idx_t i);
        src_mask_t m;
        m    = '0;
        m[i] = 1'b1;
        return m;
    endfunction

    function automatic eoi_cmd_t decode_eoi(logic en, logic [VEC_W-1:0] data);
        eoi_cmd_t c;
        c.valid    = en;
        c.specific = data[IDX_W];
        c.idx      = data[IDX_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/nic_prio_pick.sv
module nic_prio_pick
    import nic_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic [N_SRC-1:0] mask_i,
    output prio_t            pick_o
);
    localparam int IW = $clog2(N_SRC);

    logic [N_SRC:0]   seen;
    logic [N_SRC-1:0] onehot;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_chain
            assign seen[g+1]  = seen[g] | mask_i[g];
            assign onehot[g]  = mask_i[g] & ~seen[g];
        end
    endgenerate

    always_comb begin
        pick_o.found = seen[N_SRC];
        pick_o.idx   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (onehot[i]) pick_o.idx = pick_o.idx | IW'(i);
        end
    end

    always_comb begin
        assert ($onehot0(onehot)) else $error("p_single_winner_r4");
    end
endmodule

// File: rtl/nic_req_latch.sv
module nic_req_latch
    import nic_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] edge_w;

    assign edge_w = req_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= req_i;
            pend_q <= (pend_q & ~clr_i) | edge_w;
        end
    end

    assign pend_o = pend_q;

    // R2: without a fresh rising edge no pending bit can appear
    p_edge_only_r2: assert property (@(posedge clk) disable iff (rst)
        (edge_w == '0) |=> ((pend_q & ~$past(pend_q)) == '0))
        else $error("p_edge_only_r2");
endmodule

// File: rtl/nic_inservice.sv
module nic_inservice
    import nic_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_i,
    input  src_idx_t         set_idx_i,
    input  eoi_cmd_t         eoi_i,
    output logic [N_SRC-1:0] isr_o,
    output prio_t            top_o
);
    logic [N_SRC-1:0] isr_q;
    logic [N_SRC-1:0] set_mask;
    logic [N_SRC-1:0] clr_mask;
    prio_t            top_w;

    nic_prio_pick #(.N_SRC(N_SRC)) u_top (
        .mask_i (isr_q),
        .pick_o (top_w)
    );

    always_comb begin
        set_mask = set_i ? N_SRC'(idx_to_mask(set_idx_i)) : '0;
        clr_mask = '0;
        if (eoi_i.valid) begin
            if (eoi_i.specific)
                clr_mask = N_SRC'(idx_to_mask(eoi_i.idx));
            else if (top_w.found)
                clr_mask = N_SRC'(idx_to_mask(top_w.idx));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= (isr_q & ~clr_mask) | set_mask;
    end

    assign isr_o = isr_q;
    assign top_o = top_w;

    // R13: in-service bits only drop under an end-of-interrupt command
    p_isr_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        !eoi_i.valid |=> (($past(isr_q) & ~isr_q) == '0))
        else $error("p_isr_sticky_r13");

    // R12: a specific command removes the named bit
    p_spec_clear_r12: assert property (@(posedge clk) disable iff (rst)
        (eoi_i.valid && eoi_i.specific && !(set_i && set_idx_i == eoi_i.idx))
        |=> !isr_q[$past(eoi_i.idx)])
        else $error("p_spec_clear_r12");

    // R11: a non-specific command removes at most one bit
    p_ns_single_r11: assert property (@(posedge clk) disable iff (rst)
        (eoi_i.valid && !eoi_i.specific && !set_i)
        |=> ($countones($past(isr_q) & ~isr_q) <= 1))
        else $error("p_ns_single_r11");
endmodule

// File: rtl/nic_top.sv
module nic_top
    import nic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  req_i,
    input  logic             ack_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [VEC_W-1:0] wr_data_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o
);
    src_mask_t  pend;
    src_mask_t  isr;
    src_mask_t  grant_clr;
    prio_t      pend_top;
    prio_t      isr_top;
    vec_base_t  base_q;
    logic [VEC_W-1:0] vec_q;
    eoi_cmd_t   eoi;
    wr_target_e wr_tgt;
    logic       grant;

    assign wr_tgt = wr_target_e'(wr_sel_i);
    assign eoi    = decode_eoi(wr_en_i && (wr_tgt == WR_EOI), wr_data_i);

    nic_req_latch #(.N_SRC(NSRC)) u_req (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .clr_i  (grant_clr),
        .pend_o (pend)
    );

    nic_prio_pick #(.N_SRC(NSRC)) u_pick (
        .mask_i (pend),
        .pick_o (pend_top)
    );

    nic_inservice #(.N_SRC(NSRC)) u_isr (
        .clk       (clk),
        .rst       (rst),
        .set_i     (grant),
        .set_idx_i (pend_top.idx),
        .eoi_i     (eoi),
        .isr_o     (isr),
        .top_o     (isr_top)
    );

    assign irq_o     = pend_top.found && (!isr_top.found || (pend_top.idx < isr_top.idx));
    assign grant     = ack_i && irq_o;
    assign grant_clr = grant ? idx_to_mask(pend_top.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            vec_q  <= '0;
        end else begin
            if (wr_en_i && wr_tgt == WR_BASE)
                base_q <= wr_data_i[VEC_W-1:IDX_W];
            if (ack_i)
                vec_q <= {base_q, (grant ? pend_top.idx : {IDX_W{1'b1}})};
        end
    end

    assign vec_o = vec_q;

    // R5: the vector carries the base held at the acknowledge edge
    p_vec_base_r5: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> (vec_o[VEC_W-1:IDX_W] == $past(base_q)))
        else $error("p_vec_base_r5");

    // R9: an empty acknowledge returns the all-ones source number
    p_idle_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_o) |=> (vec_o[IDX_W-1:0] == {IDX_W{1'b1}}))
        else $error("p_idle_ack_r9");

    // R6: a grant adds exactly one in-service bit
    p_isr_grows_r6: assert property (@(posedge clk) disable iff (rst)
        (grant && !eoi.valid) |=> ($countones(isr) == $countones($past(isr)) + 1))
        else $error("p_isr_grows_r6");

    // R5: vector is held between acknowledges
    p_vec_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> $stable(vec_o))
        else $error("p_vec_hold_r5");

    // R3: the interrupt line needs a pending request
    p_irq_pending_r3: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend != '0))
        else $error("p_irq_pending_r3");
endmodule

// File: tb/tb_nic_top.sv
module tb_nic_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0;
    logic       ack_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_sel_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       irq_o;
    logic [7:0] vec_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_top dut (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .ack_i     (ack_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .irq_o     (irq_o),
        .vec_o     (vec_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check(irq_o === exp, tag, int'(irq_o), int'(exp));
    endtask

    task automatic chk_vec(input logic [7:0] exp, input string tag);
        check(vec_o === exp, tag, int'(vec_o), int'(exp));
    endtask

    task automatic pulse_req(input logic [7:0] m);
        @(negedge clk) req_i = req_i | m;
        @(negedge clk) req_i = req_i & ~m;
    endtask

    task automatic do_ack();
        @(negedge clk) ack_i = 1'b1;
        @(negedge clk) ack_i = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk) begin wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d; end
        @(negedge clk) begin wr_en_i = 1'b0; wr_data_i = '0; end
    endtask

    task automatic set_base(input logic [4:0] b);
        wr(1'b0, {b, 3'b000});
    endtask

    task automatic eoi_ns();
        wr(1'b1, 8'h00);
    endtask

    task automatic eoi_spec(input logic [2:0] k);
        wr(1'b1, {4'b0000, 1'b1, k});
    endtask

    task automatic t_reset();
        chk_irq(1'b0, "R1 irq after reset");
        chk_vec(8'h00, "R1 vector after reset");
        do_ack();
        chk_vec(8'h07, "R1 base zero, R9 empty ack");
    endtask

    task automatic t_vector();
        set_base(5'h15);
        pulse_req(8'h20);
        chk_irq(1'b1, "R3 irq for source 5");
        do_ack();
        chk_vec(8'hAD, "R5 vector base 0x15 source 5");
        chk_irq(1'b0, "R6 request cleared on grant");
        repeat (3) @(negedge clk);
        chk_vec(8'hAD, "R5 vector held");
        eoi_ns();
        chk_irq(1'b0, "R2 nothing pending after eoi");
    endtask

    task automatic t_priority();
        set_base(5'h00);
        pulse_req(8'h44);
        do_ack();
        chk_vec(8'h02, "R4 source 2 beats 6");
        chk_irq(1'b0, "R7 source 6 masked by 2");
        eoi_ns();
        chk_irq(1'b1, "R11 source 6 released");
        do_ack();
        chk_vec(8'h06, "R4 source 6 next");
        eoi_ns();
    endtask

    task automatic t_nesting();
        pulse_req(8'h10);
        do_ack();
        chk_vec(8'h04, "R4 source 4 granted");
        pulse_req(8'h10);
        chk_irq(1'b0, "R7 equal priority masked");
        pulse_req(8'h02);
        chk_irq(1'b1, "R8 source 1 nests over 4");
        do_ack();
        chk_vec(8'h01, "R8 nested vector source 1");
        pulse_req(8'h08);
        chk_irq(1'b0, "R7 source 3 masked by 1");
        eoi_ns();
        chk_irq(1'b1, "R11 ns eoi cleared source 1 only");
        do_ack();
        chk_vec(8'h03, "R4 source 3 granted");
        eoi_ns();
        chk_irq(1'b0, "R13 source 4 still in service");
        eoi_ns();
        chk_irq(1'b1, "R11 source 4 cleared");
        do_ack();
        chk_vec(8'h04, "R2 second source 4 latch");
        eoi_ns();
    endtask

    task automatic t_specific();
        pulse_req(8'h20);
        do_ack();
        pulse_req(8'h04);
        do_ack();
        chk_vec(8'h02, "R8 source 2 over 5");
        pulse_req(8'h08);
        chk_irq(1'b0, "R7 source 3 masked by 2");
        eoi_spec(3'd5);
        chk_irq(1'b0, "R12 specific eoi kept source 2");
        eoi_spec(3'd2);
        chk_irq(1'b1, "R12 specific eoi cleared source 2");
        do_ack();
        chk_vec(8'h03, "R4 source 3 after specific eoi");
        eoi_spec(3'd3);
        chk_irq(1'b0, "R12 idle after cleanup");
    endtask

    task automatic t_level();
        @(negedge clk) req_i[6] = 1'b1;
        @(negedge clk);
        chk_irq(1'b1, "R2 edge latched source 6");
        do_ack();
        chk_vec(8'h06, "R2 source 6 vector");
        eoi_ns();
        repeat (3) @(negedge clk);
        chk_irq(1'b0, "R2 held level does not relatch");
        @(negedge clk) req_i[6] = 1'b0;
    endtask

    task automatic t_empty_ack();
        set_base(5'h1F);
        do_ack();
        chk_vec(8'hFF, "R9 empty ack gives source 7");
        pulse_req(8'h80);
        chk_irq(1'b1, "R9 empty ack set no in-service bit");
        do_ack();
        chk_vec(8'hFF, "R4 source 7 granted");
        pulse_req(8'h01);
        chk_irq(1'b1, "R8 source 0 over 7");
        set_base(5'h0A);
        do_ack();
        chk_vec(8'h50, "R10 new base in running handler");
        eoi_ns();
        eoi_ns();
        chk_irq(1'b0, "R11 all cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_vector();
        t_priority();
        t_nesting();
        t_specific();
        t_level();
        t_empty_ack();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule